// File: doc/BRIEF.md
# Receive Byte Ordering Correction

This block sits behind a transceiver receiver whose deserializer delivers two decoded bytes per parallel clock, each byte with its own control flag. Because the transmit and receive channels come out of reset independently, and because supply, signal and thermal effects can move the word boundary while running, the first byte of the stream may arrive in the high lane. When that happens, every later word is split across two parallel words in the same way.

The block looks at every word for the K28.5 comma (byte value 0xBC with its control flag set). A comma in the high lane puts the block into swapped mode. In that mode each output word pairs the high byte held from the previous word with the low byte of the current word, so the comma lands in the low lane. A comma in the low lane returns the block to pass-through mode. The search never stops, so the block follows boundary shifts whenever they occur. Outputs are registered one cycle behind the input. The block is cleared while the active-low reset is asserted or while the receiver reports that it has lost sync.

Top module: `rx_byte_order_fix`

## Requirements
- R1: While `rst_n` is low or `sync_ok` is low at a rising edge, after that edge `out_valid`, `out_data`, `out_ctl` and `swapped` are all 0.
- R2: Each word accepted while enabled (`rst_n` and `sync_ok` both high) produces its result one rising edge later, with `out_valid` high.
- R3: A lane counts as holding a comma only if its byte equals 0xBC and its own control flag is set. Lane 0 is bits 7:0 with flag bit 0, and lane 1 is bits 15:8 with flag bit 1. A 0xBC byte without its flag, or a flag on another byte value, has no effect on the mode.
- R4: In pass-through mode, `out_data` and `out_ctl` equal the input word and flags unchanged.
- R5: A word with a comma in lane 1 and none in lane 0 is itself output in the mode held before it, and sets `swapped` to 1 from the next edge.
- R6: In swapped mode, for a word without a lane-0 comma, `out_data[7:0]` is the previous accepted word's lane-1 byte and `out_data[15:8]` is the current lane-0 byte. Bits 0 and 1 of `out_ctl` are the matching flags.
- R7: A word with a comma in lane 0 is output unchanged, even in swapped mode, and sets `swapped` to 0.
- R8: A word with no comma in either lane leaves `swapped` as it was.
- R9: When both lanes hold a comma, lane 0 takes priority: the word passes unchanged and `swapped` becomes 0.
- R10: After sync is lost and regained, the block restarts in pass-through mode, and no byte held from before the loss appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock from the receiver |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_ok | input | 1 | Receiver word sync indication; low clears the block |
| in_data | input | 16 | Decoded double-width word, lane 0 in bits 7:0 |
| in_ctl | input | 2 | Per-lane control flags, bit i for lane i |
| out_data | output | 16 | Reordered word |
| out_ctl | output | 2 | Control flags that travel with `out_data` |
| out_valid | output | 1 | High when `out_data` holds a result |
| swapped | output | 1 | High while the block is in swapped mode |

## Verification
Every result is due one rising edge after its input word: the data, flags and valid bit of the word, and the mode that word leaves behind as shown by `swapped`. The only result that reaches two words back is the low output byte in swapped mode, which comes from the word before. The bench drives each word on a falling edge. At the next falling edge it compares all four outputs against a behavioural model that was advanced by that same word, so each comparison falls exactly one edge after its stimulus. The stimulus covers directed comma placements, flagless 0xBC bytes, commas in both lanes and a loss of sync while swapped, followed by a long random stream with mixed comma positions.

// File: rtl/rx_byte_order_pkg.sv
// Package: shared constants and types for the receive byte ordering path.
// Assumes 8b/10b decoded bytes; the comma value is the decoded K28.5 code.
package rx_byte_order_pkg;

    localparam int unsigned BYTE_BITS  = 8;
    localparam logic [BYTE_BITS-1:0] K28_5_CODE = 8'hBC;

    // Lane pairing currently applied to the byte stream.
    typedef enum logic {
        PAIR_DIRECT  = 1'b0,
        PAIR_SPLICED = 1'b1
    } pair_mode_e;

endpackage

// File: rtl/rx_comma_scan.sv
// Module: rx_comma_scan
// Flags each byte lane that holds the comma with its control bit set.
// Assumes lane i occupies bits [i*BYTE_W +: BYTE_W] with flag ctl[i].
// Purely combinational; one hit bit per lane.
module rx_comma_scan #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 2,
    parameter logic [BYTE_W-1:0] COMMA = 8'hBC,
    localparam int unsigned WORD_W = BYTE_W * LANES
) (
    input  logic [WORD_W-1:0] data,
    input  logic [LANES-1:0]  ctl,
    output logic [LANES-1:0]  hit
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Compare one lane against the comma, qualified by its flag.
            always_comb begin
                hit[g] = ctl[g] && (data[g*BYTE_W +: BYTE_W] == COMMA);
            end
        end
    endgenerate

endmodule

// File: rtl/rx_pair_mode.sv
// Module: rx_pair_mode
// Tracks whether the byte stream must be spliced across words.
// A low-lane comma wins and selects direct pairing at once for the current
// word; a high-lane comma selects splicing from the next word on.
// Assumes run is the combined reset/sync enable, sampled synchronously.
module rx_pair_mode
    import rx_byte_order_pkg::*;
(
    input  logic       clk,
    input  logic       run,
    input  logic       hit_lo,
    input  logic       hit_hi,
    output logic       splice_now,
    output pair_mode_e mode_q
);

    pair_mode_e mode_d;

    // Pick the pairing for the word in flight and the mode it leaves behind.
    always_comb begin
        splice_now = (mode_q == PAIR_SPLICED) && !hit_lo;
        if (hit_lo) begin
            mode_d = PAIR_DIRECT;
        end else if (hit_hi) begin
            mode_d = PAIR_SPLICED;
        end else begin
            mode_d = mode_q;
        end
    end

    // Hold the pairing mode; cleared whenever the block is not running.
    always_ff @(posedge clk) begin
        if (!run) begin
            mode_q <= PAIR_DIRECT;
        end else begin
            mode_q <= mode_d;
        end
    end

    // R5
    hi_comma_enters_splice_chk: assert property (@(posedge clk) disable iff (!run)
        (hit_hi && !hit_lo) |=> (mode_q == PAIR_SPLICED));

    // R7
    lo_comma_leaves_splice_chk: assert property (@(posedge clk) disable iff (!run)
        hit_lo |=> (mode_q == PAIR_DIRECT));

    // R8
    no_comma_keeps_mode_chk: assert property (@(posedge clk) disable iff (!run)
        (!hit_lo && !hit_hi) |=> $stable(mode_q));

endmodule

// File: rtl/rx_lane_splice.sv
// Module: rx_lane_splice
// Builds the output word either directly from the input or by joining the
// previous word's top byte (new low lane) with the current low byte.
// Assumes exactly two lanes; one register stage on every output.
module rx_lane_splice #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned LANES  = 2,
    localparam int unsigned WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              run,
    input  logic              splice_now,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_ctl,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_ctl,
    output logic              out_valid
);

    logic [BYTE_W-1:0] held_byte;
    logic              held_flag;
    logic [WORD_W-1:0] word_d;
    logic [LANES-1:0]  ctl_d;

    // Choose direct or spliced pairing for the word in flight.
    always_comb begin
        if (splice_now) begin
            word_d = {in_data[BYTE_W-1:0], held_byte};
            ctl_d  = {in_ctl[0], held_flag};
        end else begin
            word_d = in_data;
            ctl_d  = in_ctl;
        end
    end

    // Keep the top byte and flag of the last accepted word.
    always_ff @(posedge clk) begin
        if (!run) begin
            held_byte <= '0;
            held_flag <= 1'b0;
        end else begin
            held_byte <= in_data[WORD_W-1 -: BYTE_W];
            held_flag <= in_ctl[LANES-1];
        end
    end

    // Register the result with its valid bit.
    always_ff @(posedge clk) begin
        if (!run) begin
            out_data  <= '0;
            out_ctl   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_data  <= word_d;
            out_ctl   <= ctl_d;
            out_valid <= 1'b1;
        end
    end

    // R4
    direct_copy_chk: assert property (@(posedge clk) disable iff (!run)
        !splice_now |=> (out_data == $past(in_data) && out_ctl == $past(in_ctl)));

    // R6
    splice_low_lane_chk: assert property (@(posedge clk) disable iff (!run)
        (splice_now && $past(run)) |=>
            (out_data[BYTE_W-1:0] == $past(in_data[WORD_W-1 -: BYTE_W], 2)));

    // R2
    valid_follows_run_chk: assert property (@(posedge clk) disable iff (!run)
        run |=> out_valid);

endmodule

// File: rtl/rx_byte_order_fix.sv
// Module: rx_byte_order_fix (top)
// Realigns a two-byte-per-clock receive stream so the K28.5 comma always
// sits in the low lane, following boundary shifts at any time.
// Assumes clk is the receiver's recovered parallel clock and that in_data
// is already 8b/10b decoded. Synchronous active-low reset; sync_ok low also
// clears all state.
module rx_byte_order_fix
    import rx_byte_order_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_BITS,
    parameter logic [BYTE_W-1:0] COMMA = K28_5_CODE,
    localparam int unsigned LANES  = 2,
    localparam int unsigned WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_ok,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_ctl,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_ctl,
    output logic              out_valid,
    output logic              swapped
);

    logic             run;
    logic [LANES-1:0] lane_hit;
    logic             splice_now;
    pair_mode_e       mode_q;

    // Block runs only out of reset and with the receiver in sync.
    always_comb begin
        run     = rst_n && sync_ok;
        swapped = (mode_q == PAIR_SPLICED);
    end

    rx_comma_scan #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES),
        .COMMA  (COMMA)
    ) u_scan (
        .data (in_data),
        .ctl  (in_ctl),
        .hit  (lane_hit)
    );

    rx_pair_mode u_mode (
        .clk        (clk),
        .run        (run),
        .hit_lo     (lane_hit[0]),
        .hit_hi     (lane_hit[LANES-1]),
        .splice_now (splice_now),
        .mode_q     (mode_q)
    );

    rx_lane_splice #(
        .BYTE_W (BYTE_W)
    ) u_splice (
        .clk        (clk),
        .run        (run),
        .splice_now (splice_now),
        .in_data    (in_data),
        .in_ctl     (in_ctl),
        .out_data   (out_data),
        .out_ctl    (out_ctl),
        .out_valid  (out_valid)
    );

    // R1
    idle_clears_chk: assert property (@(posedge clk)
        !run |=> (!out_valid && out_data == '0 && out_ctl == '0 && !swapped));

    // R9
    both_commas_direct_chk: assert property (@(posedge clk) disable iff (!run)
        (lane_hit == {LANES{1'b1}}) |=> (!swapped && out_data == $past(in_data)));

endmodule

// File: tb/tb_rx_byte_order_fix.sv
module tb_rx_byte_order_fix;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] K = 8'hBC;

    logic        clk = 1'b0;
    logic        rst_n, sync_ok;
    logic [15:0] in_data;
    logic [1:0]  in_ctl;
    logic [15:0] out_data;
    logic [1:0]  out_ctl;
    logic        out_valid, swapped;

    int total = 0;
    int bad   = 0;

    // reference model state
    int         m_mode = 0;
    logic [7:0] m_hb   = '0;
    logic       m_hf   = 1'b0;
    logic [15:0] e_data = '0;
    logic [1:0]  e_ctl  = '0;
    logic        e_valid = 1'b0, e_sw = 1'b0;
    bit          have_exp = 1'b0;
    string       cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_byte_order_fix dut (
        .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok),
        .in_data(in_data), .in_ctl(in_ctl),
        .out_data(out_data), .out_ctl(out_ctl),
        .out_valid(out_valid), .swapped(swapped)
    );

    task automatic check_outputs();
        total++;
        if (out_data !== e_data || out_ctl !== e_ctl ||
            out_valid !== e_valid || swapped !== e_sw) begin
            bad++;
            $display("FAIL %s: got data=%h ctl=%b v=%b sw=%b exp data=%h ctl=%b v=%b sw=%b",
                     cur_req, out_data, out_ctl, out_valid, swapped,
                     e_data, e_ctl, e_valid, e_sw);
        end
    endtask

    // Apply one word at a falling edge after checking the previous result.
    task automatic step(input string req, input logic r, input logic s,
                        input logic [15:0] d, input logic [1:0] c);
        @(negedge clk);
        if (have_exp) check_outputs();
        cur_req = req;
        rst_n = r; sync_ok = s; in_data = d; in_ctl = c;
        if (!(r && s)) begin
            m_mode = 0; m_hb = '0; m_hf = 1'b0;
            e_data = '0; e_ctl = '0; e_valid = 1'b0; e_sw = 1'b0;
        end else begin
            bit lo_k, hi_k, use_splice;
            lo_k = c[0] && d[7:0] == K;
            hi_k = c[1] && d[15:8] == K;
            use_splice = (m_mode == 1) && !lo_k;
            if (use_splice) begin
                e_data = {d[7:0], m_hb};
                e_ctl  = {c[0], m_hf};
            end else begin
                e_data = d;
                e_ctl  = c;
            end
            e_valid = 1'b1;
            if (lo_k) m_mode = 0;
            else if (hi_k) m_mode = 1;
            e_sw = (m_mode == 1);
            m_hb = d[15:8];
            m_hf = c[1];
        end
        have_exp = 1'b1;
    endtask

    function automatic logic [7:0] nk(input logic [7:0] b);
        return (b == K) ? (b ^ 8'h01) : b;
    endfunction

    function automatic logic [15:0] rnd_word();
        logic [15:0] w;
        w = 16'($urandom);
        return {nk(w[15:8]), nk(w[7:0])};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got hang exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sync_ok = 1'b0; in_data = '0; in_ctl = '0;
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1", 1'b0, 1'b1, rnd_word(), 2'b11);
        // R2 R4: pass-through of plain data
        for (int i = 0; i < 8; i++) step("R4", 1'b1, 1'b1, rnd_word(), 2'($urandom));
        // R7: low-lane comma while direct
        step("R7", 1'b1, 1'b1, {8'h4A, K}, 2'b01);
        step("R4", 1'b1, 1'b1, 16'h1234, 2'b00);
        // R3: 0xBC without flag in high lane, flag on other value
        step("R3", 1'b1, 1'b1, {K, 8'h55}, 2'b01);
        step("R3", 1'b1, 1'b1, {8'h3C, 8'h66}, 2'b10);
        step("R3", 1'b1, 1'b1, 16'h7788, 2'b00);
        // R5: comma in high lane enters splice
        step("R5", 1'b1, 1'b1, {K, 8'h11}, 2'b10);
        // R6: spliced stream, comma repeats in high lane
        for (int i = 0; i < 6; i++) step("R6", 1'b1, 1'b1, {K, 8'(8'h20 + i)}, 2'b10);
        // R8: no comma keeps splice
        for (int i = 0; i < 6; i++) step("R8", 1'b1, 1'b1, rnd_word(), 2'($urandom));
        // R3: flagless comma in low lane does not leave splice
        step("R3", 1'b1, 1'b1, {8'h99, K}, 2'b00);
        step("R3", 1'b1, 1'b1, 16'hA1B2, 2'b00);
        // R9: both lanes comma
        step("R9", 1'b1, 1'b1, {K, K}, 2'b11);
        step("R9", 1'b1, 1'b1, 16'hC3D4, 2'b00);
        // R7: leave splice via low comma
        step("R5", 1'b1, 1'b1, {K, 8'h01}, 2'b10);
        step("R6", 1'b1, 1'b1, 16'h0203, 2'b00);
        step("R7", 1'b1, 1'b1, {8'h05, K}, 2'b01);
        step("R7", 1'b1, 1'b1, 16'h0607, 2'b00);
        // R10: lose sync while spliced
        step("R5", 1'b1, 1'b1, {K, 8'h08}, 2'b10);
        step("R6", 1'b1, 1'b1, {8'hEE, 8'h09}, 2'b10);
        step("R1", 1'b1, 1'b0, 16'hFFFF, 2'b11);
        step("R1", 1'b1, 1'b0, {K, 8'h00}, 2'b10);
        for (int i = 0; i < 4; i++) step("R10", 1'b1, 1'b1, rnd_word(), 2'($urandom));
        // mixed random stream
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [15:0] w;
            logic [1:0]  c;
            sel = $urandom_range(0, 9);
            w = rnd_word();
            c = 2'($urandom);
            if (sel == 0) w[7:0] = K;
            if (sel == 1) w[15:8] = K;
            if (sel == 2) w = {K, K};
            if (i % 500 == 499) step("R1", 1'b1, 1'b0, w, c);
            else step("R6", 1'b1, 1'b1, w, c);
        end
        @(negedge clk);
        check_outputs();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule